// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block turns a 48-bit virtual address into a physical address by reading a four-level radix page table held in memory. A requester presents a virtual address, an access kind (read, write or instruction fetch) and a flag saying whether the access comes from unprivileged code. The block uses the root-table base present on `root_base` when the request is accepted. It then fetches one 8-byte entry per level through a 64-bit read port. At every level it checks the entry's permissions, and it stops early when an entry at the second or third level maps a 1GB or 2MB page.

Each translation ends in one response. The response holds either the physical address or a fault, together with a fault code and the level where the walk stopped. All three data paths use valid/ready. The request is taken only while the walker is idle, so `req_ready` is low for the whole of a walk. A read request stays asserted with a constant address until `mem_req_ready` accepts it. At most one read is outstanding, and `mem_rsp_ready` is high only while that read is awaited. A response stays valid and unchanged until `rsp_ready` is seen high on a clock edge.

Top module: `ptw_walker`

## Requirements
- R1: The level-n read (n = 1..4) goes to table base + 8 * index, where the indexes are taken from the virtual address from the top down: level 1 from bits 47:39, level 2 from 38:30, level 3 from 29:21 and level 4 from 20:12.
- R2: A virtual address whose bits 63:48 are not all equal to bit 47 completes with fault code 5, fault level 0, and no memory read. Addresses with bits 63:47 all ones are valid.
- R3: The next table base, or the final page base, is entry bits 47:12 with the low 12 bits forced to zero. Entry bits 62:48 have no effect.
- R4: An entry with bit 0 (present) clear ends the walk with fault code 1, for any access kind.
- R5: A write access (`req_acc` = 1) through an entry with bit 1 (writable) clear faults with code 2.
- R6: An unprivileged access (`req_user` = 1) through an entry with bit 2 (user) clear faults with code 3.
- R7: An instruction fetch (`req_acc` = 2) through an entry with bit 63 (no-execute) set faults with code 4. For reads and writes, bit 63 has no effect. `req_acc` = 3 behaves as a read.
- R8: Within one entry, the checks take priority in the order present, user, writable, no-execute. The walk stops at the first failing level and issues no further read. `rsp_fault_level` gives that level (1 to 4), and `rsp_pa` is zero on any fault.
- R9: A level-2 entry with bit 7 (size) set ends the walk after 2 reads, with `rsp_pa` = {entry[47:30], va[29:0]}.
- R10: A level-3 entry with bit 7 set ends the walk after 3 reads, with `rsp_pa` = {entry[47:21], va[20:0]}. Bit 7 has no effect at levels 1 and 4.
- R11: Otherwise the walk takes exactly 4 reads and returns `rsp_pa` = {level-4 entry[47:12], va[11:0]}, with `rsp_fault` = 0, code 0 and level 0.
- R12: `req_ready` is high only while idle. A response, once valid, keeps all of its fields constant until accepted.
- R13: `root_base` is sampled when the request is accepted. Changing it during a walk does not affect that walk.
- R14: A read request keeps its address constant until accepted, and only one read is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_va | input | 64 | Virtual address |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 fetch |
| req_user | input | 1 | Access made by unprivileged code |
| root_base | input | PA_BITS | Root table base, 4096-byte aligned |
| mem_req_valid | output | 1 | Entry read request valid |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_req_addr | output | PA_BITS | Byte address of the entry |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_ready | output | 1 | Walker awaiting read data |
| mem_rsp_data | input | 64 | Entry value |
| rsp_valid | output | 1 | Translation result valid |
| rsp_ready | input | 1 | Requester accepts the result |
| rsp_pa | output | PA_BITS | Physical address (zero on fault) |
| rsp_fault | output | 1 | Translation faulted |
| rsp_fault_code | output | 3 | 0 none, 1 not present, 2 write denied, 3 privilege denied, 4 no-execute, 5 non-canonical |
| rsp_fault_level | output | LVL_W | Level of the failing entry (1..4), 0 otherwise |

## Verification
The bench uses the default parameters: a 48-bit virtual and physical address, four levels of 9-bit indexes and a 12-bit page offset. With these values the full four-read walk and both large-page sizes can be reached, along with the sign-extended upper half of the address space. Random tables are built from random flags and random 20-bit page numbers. The memory model applies random request stalls and response delays, and the bench holds off each response for a random time. Together these exercise the hold rules on all three channels and the early stop at every level.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2
  } acc_e;

  typedef enum logic [2:0] {
    FC_NONE        = 3'd0,
    FC_NOT_PRESENT = 3'd1,
    FC_WRITE       = 3'd2,
    FC_PRIV        = 3'd3,
    FC_NOEXEC      = 3'd4,
    FC_NONCANON    = 3'd5
  } fault_e;

  // entry flag positions
  localparam int BIT_PRESENT = 0;
  localparam int BIT_WRITE   = 1;
  localparam int BIT_USER    = 2;
  localparam int BIT_SIZE    = 7;
  localparam int BIT_NOEXEC  = 63;

endpackage

// File: rtl/ptw_va_decode.sv
module ptw_va_decode #(
  parameter int VA_BITS  = 48,
  parameter int LEVELS   = 4,
  parameter int IDX_BITS = 9,
  parameter int OFF_BITS = 12,
  localparam int STEP_W  = $clog2(LEVELS),
  localparam int TOP_W   = 64 - VA_BITS + 1
) (
  input  logic [63:0]         va,
  input  logic [STEP_W-1:0]   step,
  output logic                canonical,
  output logic [IDX_BITS-1:0] idx
);

  logic [IDX_BITS-1:0] slice [LEVELS];
  logic [TOP_W-1:0]    sign_bits;
  logic                unused_low;

  // step 0 uses the most significant index
  for (genvar g = 0; g < LEVELS; g++) begin : g_slice
    localparam int LSB = OFF_BITS + IDX_BITS * (LEVELS - 1 - g);
    assign slice[g] = va[LSB +: IDX_BITS];
  end

  assign idx        = slice[step];
  assign sign_bits  = va[63:VA_BITS-1];
  assign canonical  = (&sign_bits) | ~(|sign_bits);
  assign unused_low = ^va[OFF_BITS-1:0];

endmodule

// File: rtl/ptw_entry_check.sv
module ptw_entry_check
  import ptw_pkg::*;
#(
  parameter int PA_BITS  = 48,
  parameter int OFF_BITS = 12,
  parameter int LEVELS   = 4,
  localparam int STEP_W  = $clog2(LEVELS)
) (
  input  logic [63:0]        entry,
  input  logic [1:0]         acc,
  input  logic               user,
  input  logic [STEP_W-1:0]  step,
  output fault_e             fault_code,
  output logic               leaf,
  output logic [PA_BITS-1:0] next_base
);

  logic size_allowed;
  logic unused_entry;

  always_comb begin
    if (!entry[BIT_PRESENT])
      fault_code = FC_NOT_PRESENT;
    else if (user && !entry[BIT_USER])
      fault_code = FC_PRIV;
    else if ((acc == ACC_WRITE) && !entry[BIT_WRITE])
      fault_code = FC_WRITE;
    else if ((acc == ACC_FETCH) && entry[BIT_NOEXEC])
      fault_code = FC_NOEXEC;
    else
      fault_code = FC_NONE;
  end

  // large pages only at the inner levels other than the last
  assign size_allowed = (step != '0) && (step != STEP_W'(LEVELS - 1));
  assign leaf         = (step == STEP_W'(LEVELS - 1)) || (size_allowed && entry[BIT_SIZE]);
  assign next_base    = {entry[PA_BITS-1:OFF_BITS], {OFF_BITS{1'b0}}};
  assign unused_entry = ^{entry[62:PA_BITS], entry[OFF_BITS-1:8], entry[6:3]};

endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int VA_BITS  = 48,
  parameter int PA_BITS  = 48,
  parameter int LEVELS   = 4,
  parameter int IDX_BITS = 9,
  parameter int OFF_BITS = 12,
  localparam int STEP_W  = $clog2(LEVELS),
  localparam int LVL_W   = $clog2(LEVELS + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [63:0]        req_va,
  input  logic [1:0]         req_acc,
  input  logic               req_user,
  input  logic [PA_BITS-1:0] root_base,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic [PA_BITS-1:0] mem_req_addr,
  input  logic               mem_rsp_valid,
  output logic               mem_rsp_ready,
  input  logic [63:0]        mem_rsp_data,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [PA_BITS-1:0] rsp_pa,
  output logic               rsp_fault,
  output logic [2:0]         rsp_fault_code,
  output logic [LVL_W-1:0]   rsp_fault_level
);

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_DONE} state_e;

  state_e             state_q;
  logic [STEP_W-1:0]  step_q;
  logic [63:0]        va_q;
  logic [1:0]         acc_q;
  logic               user_q;
  logic [PA_BITS-1:0] base_q;
  logic [PA_BITS-1:0] pa_q;
  fault_e             code_q;
  logic [LVL_W-1:0]   lvl_q;

  logic                va_ok;
  logic [IDX_BITS-1:0] idx;
  fault_e              chk_code;
  logic                chk_leaf;
  logic [PA_BITS-1:0]  chk_next;
  logic [PA_BITS-1:0]  leaf_mask;
  logic [PA_BITS-1:0]  mask_tbl [LEVELS];

  ptw_va_decode #(
    .VA_BITS (VA_BITS),
    .LEVELS  (LEVELS),
    .IDX_BITS(IDX_BITS),
    .OFF_BITS(OFF_BITS)
  ) u_dec (
    .va       (va_q),
    .step     (step_q),
    .canonical(va_ok),
    .idx      (idx)
  );

  ptw_entry_check #(
    .PA_BITS (PA_BITS),
    .OFF_BITS(OFF_BITS),
    .LEVELS  (LEVELS)
  ) u_chk (
    .entry     (mem_rsp_data),
    .acc       (acc_q),
    .user      (user_q),
    .step      (step_q),
    .fault_code(chk_code),
    .leaf      (chk_leaf),
    .next_base (chk_next)
  );

  // page offset mask for a walk that ends at each step
  for (genvar g = 0; g < LEVELS; g++) begin : g_mask
    localparam int OB = OFF_BITS + IDX_BITS * (LEVELS - 1 - g);
    assign mask_tbl[g] = (PA_BITS'(1) << OB) - PA_BITS'(1);
  end
  assign leaf_mask = mask_tbl[step_q];

  assign req_ready       = (state_q == S_IDLE);
  assign mem_req_valid   = (state_q == S_ISSUE) && va_ok;
  assign mem_req_addr    = base_q + (PA_BITS'(idx) << 3);
  assign mem_rsp_ready   = (state_q == S_WAIT);
  assign rsp_valid       = (state_q == S_DONE);
  assign rsp_pa          = pa_q;
  assign rsp_fault       = (code_q != FC_NONE);
  assign rsp_fault_code  = code_q;
  assign rsp_fault_level = lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      step_q  <= '0;
      va_q    <= '0;
      acc_q   <= '0;
      user_q  <= 1'b0;
      base_q  <= '0;
      pa_q    <= '0;
      code_q  <= FC_NONE;
      lvl_q   <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: begin
          if (req_valid) begin
            va_q    <= req_va;
            acc_q   <= req_acc;
            user_q  <= req_user;
            base_q  <= root_base;
            step_q  <= '0;
            pa_q    <= '0;
            code_q  <= FC_NONE;
            lvl_q   <= '0;
            state_q <= S_ISSUE;
          end
        end
        S_ISSUE: begin
          if (!va_ok) begin
            code_q  <= FC_NONCANON;
            state_q <= S_DONE;
          end else if (mem_req_ready) begin
            state_q <= S_WAIT;
          end
        end
        S_WAIT: begin
          if (mem_rsp_valid) begin
            if (chk_code != FC_NONE) begin
              code_q  <= chk_code;
              lvl_q   <= LVL_W'(step_q) + LVL_W'(1);
              state_q <= S_DONE;
            end else if (chk_leaf) begin
              pa_q    <= (chk_next & ~leaf_mask) | (va_q[PA_BITS-1:0] & leaf_mask);
              state_q <= S_DONE;
            end else begin
              base_q  <= chk_next;
              step_q  <= step_q + STEP_W'(1);
              state_q <= S_ISSUE;
            end
          end
        end
        S_DONE: begin
          if (rsp_ready) state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ptw_checker.sv
module ptw_checker #(
  parameter int PA_BITS  = 48,
  parameter int LEVELS   = 4,
  localparam int LVL_W   = $clog2(LEVELS + 1),
  localparam int CNT_W   = $clog2(LEVELS + 1) + 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_ready,
  input logic               mem_req_valid,
  input logic               mem_req_ready,
  input logic [PA_BITS-1:0] mem_req_addr,
  input logic               mem_rsp_ready,
  input logic               rsp_valid,
  input logic               rsp_ready,
  input logic [PA_BITS-1:0] rsp_pa,
  input logic               rsp_fault,
  input logic [2:0]         rsp_fault_code,
  input logic [LVL_W-1:0]   rsp_fault_level
);

  logic [CNT_W-1:0] rd_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_cnt <= '0;
    else if (req_valid && req_ready) rd_cnt <= '0;
    else if (mem_req_valid && mem_req_ready) rd_cnt <= rd_cnt + CNT_W'(1);
  end

  a_r14_memreq_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  a_r14_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !mem_rsp_ready);

  a_r1_entry_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> mem_req_addr[2:0] == 3'd0);

  a_r12_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_pa) && $stable(rsp_fault)
      && $stable(rsp_fault_code) && $stable(rsp_fault_level));

  a_r12_idle_only: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !rsp_valid && !mem_req_valid);

  a_r2_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault_code == 3'd5 |-> rd_cnt == '0 && rsp_fault_level == '0);

  a_r11_max_reads: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_ready |-> rd_cnt < CNT_W'(LEVELS));

  a_r8_fault_fields: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_fault == (rsp_fault_code != 3'd0)) && (rsp_fault || rsp_fault_level == '0)
      && (!rsp_fault || rsp_pa == '0));

endmodule

bind ptw_walker ptw_checker #(.PA_BITS(PA_BITS), .LEVELS(LEVELS)) u_ptw_checker (
  .clk            (clk),
  .rst_n          (rst_n),
  .req_valid      (req_valid),
  .req_ready      (req_ready),
  .mem_req_valid  (mem_req_valid),
  .mem_req_ready  (mem_req_ready),
  .mem_req_addr   (mem_req_addr),
  .mem_rsp_ready  (mem_rsp_ready),
  .rsp_valid      (rsp_valid),
  .rsp_ready      (rsp_ready),
  .rsp_pa         (rsp_pa),
  .rsp_fault      (rsp_fault),
  .rsp_fault_code (rsp_fault_code),
  .rsp_fault_level(rsp_fault_level)
);

// File: tb/ptw_walker_tb.sv
module ptw_walker_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_va = '0;
  logic [1:0]  req_acc = '0;
  logic        req_user = 1'b0;
  logic [47:0] root_base = '0;
  logic        mem_req_valid;
  logic        mem_req_ready;
  logic [47:0] mem_req_addr;
  logic        mem_rsp_valid;
  logic        mem_rsp_ready;
  logic [63:0] mem_rsp_data;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [47:0] rsp_pa;
  logic        rsp_fault;
  logic [2:0]  rsp_fault_code;
  logic [2:0]  rsp_fault_level;

  int n_checks = 0;
  int n_errors = 0;
  int n_reads  = 0;

  logic [63:0] pmem [logic [47:0]];

  always #(CLK_PERIOD / 2) clk = ~clk;

  ptw_walker u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
    .req_acc(req_acc), .req_user(req_user), .root_base(root_base),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_ready(mem_rsp_ready), .mem_rsp_data(mem_rsp_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_pa(rsp_pa), .rsp_fault(rsp_fault),
    .rsp_fault_code(rsp_fault_code), .rsp_fault_level(rsp_fault_level)
  );

  function automatic logic [63:0] rd(input logic [47:0] a);
    return pmem.exists(a) ? pmem[a] : 64'h0;
  endfunction

  // memory model with random stalls and latency
  logic        busy = 1'b0;
  logic [47:0] lat_addr;
  int          delay;
  always @(posedge clk) begin
    if (!rst_n) begin
      mem_req_ready <= 1'b0;
      mem_rsp_valid <= 1'b0;
      mem_rsp_data  <= '0;
      busy          <= 1'b0;
      delay         <= 0;
    end else begin
      if (mem_req_valid && mem_req_ready) begin
        busy          <= 1'b1;
        lat_addr      <= mem_req_addr;
        delay         <= int'($urandom % 3);
        n_reads       <= n_reads + 1;
        mem_req_ready <= 1'b0;
      end else begin
        mem_req_ready <= !busy && (($urandom % 4) != 0);
      end
      if (busy && !mem_rsp_valid) begin
        if (delay == 0) begin
          mem_rsp_valid <= 1'b1;
          mem_rsp_data  <= rd(lat_addr);
        end else begin
          delay <= delay - 1;
        end
      end
      if (mem_rsp_valid && mem_rsp_ready) begin
        mem_rsp_valid <= 1'b0;
        busy          <= 1'b0;
      end
    end
  end

  task automatic check(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // reference walk computed from the requirements
  function automatic void model(input logic [63:0] va, input logic [1:0] acc, input logic usr,
                                input logic [47:0] root, output logic [47:0] pa,
                                output logic [2:0] code, output logic [2:0] lvl, output int nrd);
    logic [47:0] base;
    logic [63:0] e;
    logic [8:0]  ix;
    base = root; pa = '0; code = 3'd0; lvl = 3'd0; nrd = 0;
    if (va[63:47] != 17'h0 && va[63:47] != 17'h1FFFF) begin
      code = 3'd5;
      return;
    end
    for (int s = 0; s < 4; s++) begin
      ix = va[39 - 9 * s +: 9];
      e  = rd(base + {36'h0, ix, 3'b000});
      nrd++;
      if (!e[0]) code = 3'd1;
      else if (usr && !e[2]) code = 3'd3;
      else if (acc == 2'd1 && !e[1]) code = 3'd2;
      else if (acc == 2'd2 && e[63]) code = 3'd4;
      if (code != 3'd0) begin
        lvl = 3'(s + 1);
        return;
      end
      if (s == 1 && e[7]) begin pa = {e[47:30], va[29:0]}; return; end
      if (s == 2 && e[7]) begin pa = {e[47:21], va[20:0]}; return; end
      if (s == 3) begin pa = {e[47:12], va[11:0]}; return; end
      base = {e[47:12], 12'h0};
    end
  endfunction

  function automatic string tag_of(input logic [2:0] code, input int nrd);
    case (code)
      3'd1: return "R4";
      3'd2: return "R5";
      3'd3: return "R6";
      3'd4: return "R7";
      3'd5: return "R2";
      default: return (nrd == 2) ? "R9" : (nrd == 3) ? "R10" : "R11";
    endcase
  endfunction

  task automatic put_chain(input logic [63:0] va, input logic [47:0] root,
                           input logic [63:0] e1, input logic [63:0] e2,
                           input logic [63:0] e3, input logic [63:0] e4);
    logic [47:0] b;
    b = root;             pmem[b + {36'h0, va[47:39], 3'b000}] = e1;
    b = {e1[47:12], 12'h0}; pmem[b + {36'h0, va[38:30], 3'b000}] = e2;
    b = {e2[47:12], 12'h0}; pmem[b + {36'h0, va[29:21], 3'b000}] = e3;
    b = {e3[47:12], 12'h0}; pmem[b + {36'h0, va[20:12], 3'b000}] = e4;
  endtask

  task automatic do_xact(input logic [63:0] va, input logic [1:0] acc, input logic usr,
                         input logic [47:0] root, output logic [47:0] a_pa,
                         output logic [2:0] a_code, output logic [2:0] a_lvl);
    logic [47:0] e_pa;
    logic [2:0]  e_code, e_lvl;
    int          e_rd, rd0, hold;
    logic        stable;
    logic        a_fault;
    string       tag;
    model(va, acc, usr, root, e_pa, e_code, e_lvl, e_rd);
    tag = tag_of(e_code, e_rd);
    @(negedge clk);
    root_base = root; req_va = va; req_acc = acc; req_user = usr; req_valid = 1'b1;
    rd0 = n_reads;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    root_base = {16'h0, 20'($urandom), 12'h0};   // R13: must not affect this walk
    while (!rsp_valid) @(negedge clk);
    a_pa = rsp_pa; a_code = rsp_fault_code; a_lvl = rsp_fault_level; a_fault = rsp_fault;
    hold = int'($urandom % 3);
    stable = 1'b1;
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      if (!rsp_valid || rsp_pa !== a_pa || rsp_fault_code !== a_code || rsp_fault_level !== a_lvl)
        stable = 1'b0;
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    check({tag, " (R1,R3,R13)"}, "pa", 64'(a_pa), 64'(e_pa));
    check(tag, "fault code", 64'(a_code), 64'(e_code));
    check({tag, " R8"}, "fault flag", 64'(a_fault), 64'(e_code != 3'd0));
    check({tag, " R8"}, "fault level", 64'(a_lvl), 64'(e_lvl));
    check({tag, " R14"}, "read count", 64'(n_reads - rd0), 64'(e_rd));
    check("R12", "response held", 64'(stable), 64'd1);
  endtask

  function automatic logic [63:0] rnd_entry();
    return {(($urandom % 4) == 0), 15'($urandom), 16'h0, 20'($urandom), 4'h0,
            (($urandom % 4) == 0), 4'h0, (($urandom % 4) != 0), (($urandom % 4) != 0),
            (($urandom % 16) != 0)};
  endfunction

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [47:0] pa;
    logic [2:0]  code, lvl;
    int          seed;
    seed = int'($urandom(32'h5EED_0042));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R12", "reset req_ready", 64'(req_ready), 64'd1);
    check("R12", "reset rsp_valid", 64'(rsp_valid), 64'd0);
    check("R14", "reset mem_req_valid", 64'(mem_req_valid), 64'd0);

    // self-referencing table at page 0
    for (int i = 0; i < 512; i++) pmem[48'(i * 8)] = 64'h3;
    do_xact(64'h0000_3456_789A_BCDE, 2'd0, 1'b0, 48'h0, pa, code, lvl);
    check("R11", "self-map pa", 64'(pa), 64'hCDE);
    do_xact(64'h0000_3456_789A_BCDE, 2'd0, 1'b1, 48'h0, pa, code, lvl);
    check("R6", "user on kernel entry", 64'({code, lvl}), 64'({3'd3, 3'd1}));
    do_xact(64'h0001_0000_0000_0000, 2'd0, 1'b0, 48'h0, pa, code, lvl);
    check("R2", "non-canonical", 64'({code, lvl}), 64'({3'd5, 3'd0}));
    do_xact(64'hFFFF_8000_0000_0123, 2'd1, 1'b0, 48'h0, pa, code, lvl);
    check("R2", "upper-half canonical pa", 64'(pa), 64'h123);

    // 1GB page, junk in upper flag bits of level 1
    put_chain(64'h0000_0040_4567_89AB, 48'h10000,
              64'h0ABC_0000_0001_1007, 64'h0000_0005_4000_0087, 64'h0, 64'h0);
    do_xact(64'h0000_0040_4567_89AB, 2'd0, 1'b1, 48'h10000, pa, code, lvl);
    check("R9", "1GB pa", 64'(pa), 64'h5_4567_89AB);

    // 2MB page with and without no-execute
    put_chain(64'h0000_1234_5678_9ABC, 48'h20000,
              64'h21007, 64'h22007, 64'h8000_0000_3FE0_0087, 64'h0);
    do_xact(64'h0000_1234_5678_9ABC, 2'd2, 1'b0, 48'h20000, pa, code, lvl);
    check("R7", "no-execute fetch", 64'({code, lvl}), 64'({3'd4, 3'd3}));
    do_xact(64'h0000_1234_5678_9ABC, 2'd0, 1'b0, 48'h20000, pa, code, lvl);
    check("R7", "no-execute read allowed", 64'(pa), 64'h3FF8_9ABC);
    put_chain(64'h0000_1234_5678_9ABC, 48'h20000,
              64'h21007, 64'h22007, 64'h0000_0000_3FE0_0087, 64'h0);
    do_xact(64'h0000_1234_5678_9ABC, 2'd2, 1'b0, 48'h20000, pa, code, lvl);
    check("R10", "2MB fetch pa", 64'(pa), 64'h3FF8_9ABC);

    // size bit ignored at levels 1 and 4
    put_chain(64'h0000_7654_3210_FEDC, 48'h30000,
              64'h31087, 64'h32007, 64'h33007, 64'h0000_0000_7777_7087);
    do_xact(64'h0000_7654_3210_FEDC, 2'd1, 1'b1, 48'h30000, pa, code, lvl);
    check("R10", "size bit at level 1/4 ignored", 64'(pa), 64'h7777_7EDC);

    // fault priority
    put_chain(64'h0000_0100_0000_0000, 48'h40000, 64'h8000_0000_0004_1000, 64'h0, 64'h0, 64'h0);
    do_xact(64'h0000_0100_0000_0000, 2'd1, 1'b1, 48'h40000, pa, code, lvl);
    check("R8", "present first", 64'({code, lvl}), 64'({3'd1, 3'd1}));
    put_chain(64'h0000_0100_0000_0000, 48'h40000, 64'h0000_0000_0004_1001, 64'h0, 64'h0, 64'h0);
    do_xact(64'h0000_0100_0000_0000, 2'd1, 1'b1, 48'h40000, pa, code, lvl);
    check("R8", "user before write", 64'({code, lvl}), 64'({3'd3, 3'd1}));
    do_xact(64'h0000_0100_0000_0000, 2'd1, 1'b0, 48'h40000, pa, code, lvl);
    check("R5", "write denied level 1", 64'({code, lvl}), 64'({3'd2, 3'd1}));
    put_chain(64'h0000_0100_0000_0000, 48'h40000, 64'h41007, 64'h42005, 64'h0, 64'h0);
    do_xact(64'h0000_0100_0000_0000, 2'd1, 1'b1, 48'h40000, pa, code, lvl);
    check("R5", "write denied level 2", 64'({code, lvl}), 64'({3'd2, 3'd2}));

    // random tables
    for (int t = 0; t < 300; t++) begin
      logic [63:0] va;
      logic [47:0] root;
      va = {$urandom, $urandom};
      va[63:48] = {16{va[47]}};
      if (($urandom % 8) == 0) va[63:48] = va[47] ? 16'h7FFF : 16'h0100;
      root = {16'h0, 20'($urandom), 12'h0};
      put_chain(va, root, rnd_entry(), rnd_entry(), rnd_entry(), rnd_entry());
      do_xact(va, 2'($urandom % 4), 1'($urandom), root, pa, code, lvl);
    end

    finish_run();
  end

endmodule